// File: doc/BRIEF.md
# Vector Instruction Prefix Payload Parser

This block sits behind an instruction-byte prefix decoder. When the decoder meets one of the three lead bytes that open a vector-extension prefix (0xC5 for the short two-byte vector form, 0xC4 for the long three-byte vector form, 0x62 for the four-byte extended-vector form), it pulses `startIn` with that byte on `leadByte`. From then on the parser pulls bytes from a valid/ready byte stream. It takes as many payload bytes as the lead byte calls for (one, two or three), then one more byte, which it keeps as the opcode.

On the cycle after the opcode handshake it raises one of two single-cycle strobes. `resultValid` comes with fully decoded, true-polarity fields: the register-extension bits, W, the extra source register, the vector length, the implied legacy mandatory prefix as a byte value, the opcode map, and, for the extended form, the zero-masking, broadcast/rounding and mask-register fields. `invalidOut` instead reports an illegal encoding. The parser then goes back to idle and waits for the next start.

Top module: `vecPrefixParser`

## Requirements
- R1: After reset `byteReady`, `resultValid` and `invalidOut` are all low, and they stay low until a start with a recognised lead byte arrives.
- R2: A start whose `leadByte` is not 0xC5, 0xC4 or 0x62 is ignored and `byteReady` stays low. A start pulse that arrives while a parse is in progress is ignored and does not change the number of bytes taken.
- R3: After lead 0xC5 the parser accepts exactly 2 stream bytes (1 payload and the opcode). After 0xC4 it accepts exactly 3, and after 0x62 exactly 4. `byteReady` is high until the last of those bytes is taken and low afterwards.
- R4: Short form (0xC5), payload byte bits: [7] inverted R, [6:3] inverted vvvv, [2] L, [1:0] pp. The outputs are R=~[7], srcReg={0,~[6:3]}, vecLen={0,L}, opMap=1, W=0, X=0, B=0, R'=0, isEvex=0, and zero for the mask, z and b fields.
- R5: Long form (0xC4). First byte: [7] ~R, [6] ~X, [5] ~B, [4:0] map code. Second byte: [7] W, [6:3] ~vvvv, [2] L, [1:0] pp. The outputs are the complemented extension bits, opMap equal to the 5-bit map code, and srcReg={0,~vvvv}.
- R6: Extended form (0x62). Byte 0: [7] ~R, [6] ~X, [5] ~B, [4] ~R', [3] must be 0, [2:0] map. Byte 1: [7] W, [6:3] ~vvvv, [2] must be 1, [1:0] pp. Byte 2: [7] z, [6:5] length code, [4] b, [3] ~V', [2:0] mask register. The outputs are srcReg={~V',~vvvv}, isEvex=1, and z, b and the mask register passed through unchanged.
- R7: pp is expanded to `mandPrefix` as 0 → 0x00 (none), 1 → 0x66, 2 → 0xF3, 3 → 0xF2.
- R8: `vecLen` is 0 for 128-bit, 1 for 256-bit and 2 for 512-bit. The short and long forms give only 0 or 1.
- R9: Any of the following raises `invalidOut` instead of `resultValid`: extended form with byte 0 bit 3 set, extended form with byte 1 bit 2 clear, extended form with length code 3, or a map code of 0 in either the long or the extended form.
- R10: Exactly one of `resultValid` or `invalidOut` pulses, for exactly one cycle, in the cycle after the opcode handshake. The parser is then idle.
- R11: Cycles with `byteValid` low during a parse consume nothing and produce no strobe.
- R12: `opcode` equals the stream byte taken right after the last payload byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Start pulse from the prefix decoder |
| leadByte | input | 8 | Lead byte that goes with startIn |
| byteValid | input | 1 | Stream byte present |
| byteData | input | 8 | Stream byte |
| byteReady | output | 1 | Parser takes the stream byte |
| resultValid | output | 1 | One-cycle strobe: decoded fields valid |
| invalidOut | output | 1 | One-cycle strobe: illegal encoding |
| extR | output | 1 | Register extension R (true polarity) |
| extX | output | 1 | Index extension X |
| extB | output | 1 | Base extension B |
| extRHi | output | 1 | High register extension R' |
| wBit | output | 1 | W bit |
| srcReg | output | 5 | Extra source register number |
| vecLen | output | 2 | Vector length code |
| mandPrefix | output | 8 | Implied legacy mandatory prefix byte |
| opMap | output | 5 | Opcode map number |
| isEvex | output | 1 | Result came from the four-byte form |
| zeroMask | output | 1 | Zero-masking selected |
| bcastRc | output | 1 | Broadcast / rounding control |
| maskReg | output | 3 | Mask register number |
| opcode | output | 8 | Captured opcode byte |

## Verification
The hardest case to reach from the ports is a start pulse that lands in the middle of a parse. The stimulus opens a short-form parse, pulses start with the extended-form lead byte after the parse has begun, and then supplies only the short form's two bytes. The strobe must still arrive on time with isEvex low. Stalled cycles between payload bytes are also driven to show that the byte count depends on handshakes and not on cycles. The rest of the stimulus is a full 256-value sweep of each payload byte position for every form. These sweeps reach every invalid-encoding condition.

// File: rtl/vecPrefixPkg.sv
package vecPrefixPkg;
  localparam int BYTE_W = 8;
  localparam int MAP_W  = 5;
  localparam int SRC_W  = 5;
  localparam int LEN_W  = 2;
  localparam int MASK_W = 3;

  typedef enum logic [1:0] {KIND_VEX2, KIND_VEX3, KIND_EVEX} kindT;

  // Capture strobes from control to datapath
  typedef struct packed {
    logic capP0;
    logic capP1;
    logic capP2;
    logic capOp;
  } strobeT;

  function automatic logic [BYTE_W-1:0] ppToPrefix(input logic [1:0] pp);
    case (pp)
      2'd1:    return 8'h66;
      2'd2:    return 8'hF3;
      2'd3:    return 8'hF2;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/vecPrefixCtrl.sv
module vecPrefixCtrl
  import vecPrefixPkg::*;
#(
  parameter logic [BYTE_W-1:0] LEAD_VEX2 = 8'hC5,
  parameter logic [BYTE_W-1:0] LEAD_VEX3 = 8'hC4,
  parameter logic [BYTE_W-1:0] LEAD_EVEX = 8'h62
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [BYTE_W-1:0] leadByte,
  input  logic              byteValid,
  output logic              byteReady,
  output strobeT            strb,
  output kindT              kindQ,
  output logic              doneOut
);
  typedef enum logic [1:0] {ST_IDLE, ST_PAYLOAD, ST_OPCODE, ST_DONE} stateT;
  stateT state;
  logic [1:0] slot;
  logic [1:0] lastSlot;
  logic leadOk;
  kindT leadKind;
  logic fire;

  always_comb begin
    leadOk   = 1'b1;
    leadKind = KIND_VEX2;
    if (leadByte == LEAD_VEX2)      leadKind = KIND_VEX2;
    else if (leadByte == LEAD_VEX3) leadKind = KIND_VEX3;
    else if (leadByte == LEAD_EVEX) leadKind = KIND_EVEX;
    else                            leadOk   = 1'b0;
  end

  assign lastSlot  = (kindQ == KIND_EVEX) ? 2'd2 : 2'd1;
  assign byteReady = (state == ST_PAYLOAD) || (state == ST_OPCODE);
  assign fire      = byteValid && byteReady;
  assign doneOut   = (state == ST_DONE);

  always_comb begin
    strb.capP0 = (state == ST_PAYLOAD) && fire && (slot == 2'd0);
    strb.capP1 = (state == ST_PAYLOAD) && fire && (slot == 2'd1);
    strb.capP2 = (state == ST_PAYLOAD) && fire && (slot == 2'd2);
    strb.capOp = (state == ST_OPCODE) && fire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      slot  <= 2'd0;
      kindQ <= KIND_VEX2;
    end else begin
      case (state)
        ST_IDLE:
          if (startIn && leadOk) begin
            kindQ <= leadKind;
            // the short form's only payload byte shares layout with slot 1
            slot  <= (leadKind == KIND_VEX2) ? 2'd1 : 2'd0;
            state <= ST_PAYLOAD;
          end
        ST_PAYLOAD:
          if (fire) begin
            if (slot == lastSlot) state <= ST_OPCODE;
            else                  slot  <= slot + 2'd1;
          end
        ST_OPCODE:
          if (fire) state <= ST_DONE;
        default:
          state <= ST_IDLE;
      endcase
    end
  end

  // Checker: bytes accepted since start must match the form
  logic [2:0] acceptCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                                        acceptCnt <= 3'd0;
    else if (state == ST_IDLE && startIn && leadOk)   acceptCnt <= 3'd0;
    else if (fire)                                    acceptCnt <= acceptCnt + 3'd1;
  end

  AST_BYTE_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> acceptCnt == ((kindQ == KIND_EVEX) ? 3'd4 :
                              (kindQ == KIND_VEX3) ? 3'd3 : 3'd2)); // R3

  AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.capP0, strb.capP1, strb.capP2, strb.capOp})); // R3
endmodule

// File: rtl/vecPrefixDatapath.sv
module vecPrefixDatapath
  import vecPrefixPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  kindT              kind,
  input  logic [BYTE_W-1:0] byteData,
  output logic              encBad,
  output logic              extR,
  output logic              extX,
  output logic              extB,
  output logic              extRHi,
  output logic              wBit,
  output logic [SRC_W-1:0]  srcReg,
  output logic [LEN_W-1:0]  vecLen,
  output logic [BYTE_W-1:0] mandPrefix,
  output logic [MAP_W-1:0]  opMap,
  output logic              isEvex,
  output logic              zeroMask,
  output logic              bcastRc,
  output logic [MASK_W-1:0] maskReg,
  output logic [BYTE_W-1:0] opcode
);
  logic [BYTE_W-1:0] p0, p1, p2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      p0 <= '0; p1 <= '0; p2 <= '0; opcode <= '0;
    end else begin
      if (strb.capP0) p0     <= byteData;
      if (strb.capP1) p1     <= byteData;
      if (strb.capP2) p2     <= byteData;
      if (strb.capOp) opcode <= byteData;
    end
  end

  always_comb begin
    // fields common to every form live in p1
    wBit       = p1[7];
    srcReg     = {1'b0, ~p1[6:3]};
    vecLen     = {1'b0, p1[2]};
    mandPrefix = ppToPrefix(p1[1:0]);
    extR       = ~p0[7];
    extX       = ~p0[6];
    extB       = ~p0[5];
    extRHi     = 1'b0;
    opMap      = p0[MAP_W-1:0];
    isEvex     = 1'b0;
    zeroMask   = 1'b0;
    bcastRc    = 1'b0;
    maskReg    = '0;
    encBad     = 1'b0;
    case (kind)
      KIND_VEX2: begin
        wBit  = 1'b0;
        extR  = ~p1[7];
        extX  = 1'b0;
        extB  = 1'b0;
        opMap = MAP_W'(1);
      end
      KIND_VEX3: begin
        encBad = (p0[4:0] == 5'd0);
      end
      default: begin
        extRHi   = ~p0[4];
        opMap    = MAP_W'(p0[2:0]);
        srcReg   = {~p2[3], ~p1[6:3]};
        vecLen   = p2[6:5];
        isEvex   = 1'b1;
        zeroMask = p2[7];
        bcastRc  = p2[4];
        maskReg  = p2[2:0];
        encBad   = p0[3] || !p1[2] || (p2[6:5] == 2'b11) || (p0[2:0] == 3'd0);
      end
    endcase
  end

  AST_R_UNINVERT: assert property (@(posedge clk) disable iff (!rstN)
    strb.capP0 |=> extR == !$past(byteData[7])); // R5

  AST_OPCODE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capOp |=> $stable(opcode)); // R12
endmodule

// File: rtl/vecPrefixParser.sv
module vecPrefixParser
  import vecPrefixPkg::*;
#(
  parameter logic [7:0] LEAD_VEX2 = 8'hC5,
  parameter logic [7:0] LEAD_VEX3 = 8'hC4,
  parameter logic [7:0] LEAD_EVEX = 8'h62
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startIn,
  input  logic [7:0] leadByte,
  input  logic       byteValid,
  input  logic [7:0] byteData,
  output logic       byteReady,
  output logic       resultValid,
  output logic       invalidOut,
  output logic       extR,
  output logic       extX,
  output logic       extB,
  output logic       extRHi,
  output logic       wBit,
  output logic [4:0] srcReg,
  output logic [1:0] vecLen,
  output logic [7:0] mandPrefix,
  output logic [4:0] opMap,
  output logic       isEvex,
  output logic       zeroMask,
  output logic       bcastRc,
  output logic [2:0] maskReg,
  output logic [7:0] opcode
);
  strobeT strb;
  kindT   kindQ;
  logic   doneQ;
  logic   encBad;

  vecPrefixCtrl #(
    .LEAD_VEX2(LEAD_VEX2), .LEAD_VEX3(LEAD_VEX3), .LEAD_EVEX(LEAD_EVEX)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .leadByte(leadByte),
    .byteValid(byteValid), .byteReady(byteReady), .strb(strb),
    .kindQ(kindQ), .doneOut(doneQ)
  );

  vecPrefixDatapath i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .kind(kindQ), .byteData(byteData),
    .encBad(encBad), .extR(extR), .extX(extX), .extB(extB), .extRHi(extRHi),
    .wBit(wBit), .srcReg(srcReg), .vecLen(vecLen), .mandPrefix(mandPrefix),
    .opMap(opMap), .isEvex(isEvex), .zeroMask(zeroMask), .bcastRc(bcastRc),
    .maskReg(maskReg), .opcode(opcode)
  );

  assign resultValid = doneQ && !encBad;
  assign invalidOut  = doneQ && encBad;

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid || invalidOut) |=> !(resultValid || invalidOut)); // R10

  AST_IDLE_AT_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid || invalidOut) |-> !byteReady); // R3

  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> vecLen != 2'b11); // R9

  AST_MAP_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> opMap != 5'd0); // R9
endmodule

// File: tb/test_vecPrefixParser.sv
module test_vecPrefixParser;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic [7:0] leadByte = 8'h00;
  logic byteValid = 1'b0;
  logic [7:0] byteData = 8'h00;
  logic byteReady, resultValid, invalidOut;
  logic extR, extX, extB, extRHi, wBit, isEvex, zeroMask, bcastRc;
  logic [4:0] srcReg, opMap;
  logic [1:0] vecLen;
  logic [7:0] mandPrefix, opcode;
  logic [2:0] maskReg;

  int nChecks = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vecPrefixParser i_vecPrefixParser (
    .clk(clk), .rstN(rstN), .startIn(startIn), .leadByte(leadByte),
    .byteValid(byteValid), .byteData(byteData), .byteReady(byteReady),
    .resultValid(resultValid), .invalidOut(invalidOut), .extR(extR),
    .extX(extX), .extB(extB), .extRHi(extRHi), .wBit(wBit), .srcReg(srcReg),
    .vecLen(vecLen), .mandPrefix(mandPrefix), .opMap(opMap), .isEvex(isEvex),
    .zeroMask(zeroMask), .bcastRc(bcastRc), .maskReg(maskReg), .opcode(opcode)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] prefixOf(input logic [1:0] pp);
    return (pp == 2'd0) ? 8'h00 : (pp == 2'd1) ? 8'h66 : (pp == 2'd2) ? 8'hF3 : 8'hF2;
  endfunction

  task automatic startLead(input logic [7:0] lb);
    @(negedge clk);
    startIn = 1'b1; leadByte = lb;
    @(negedge clk);
    startIn = 1'b0;
  endtask

  // returns at the negedge following the handshake edge
  task automatic sendByte(input logic [7:0] d);
    byteValid = 1'b1; byteData = d;
    while (!byteReady) @(negedge clk);
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  // kind: 0 short, 1 long, 2 extended
  task automatic runCase(input int kind, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] c, input logic [7:0] op);
    logic eR, eX, eB, eRH, eW, eEv, eZ, eBc, bad;
    logic [4:0] eSrc, eMap;
    logic [1:0] eLen, pp;
    logic [2:0] eMask;
    string tag;
    startLead(kind == 0 ? 8'hC5 : kind == 1 ? 8'hC4 : 8'h62);
    sendByte(a);
    if (kind >= 1) sendByte(b);
    if (kind == 2) sendByte(c);
    chk("R3 ready before opcode", {63'd0, byteReady}, 64'd1);
    sendByte(op);
    eRH = 0; eEv = 0; eZ = 0; eBc = 0; eMask = 0; bad = 0;
    if (kind == 0) begin
      tag = "R4"; eR = ~a[7]; eX = 0; eB = 0; eW = 0;
      eSrc = {1'b0, ~a[6:3]}; eLen = {1'b0, a[2]}; pp = a[1:0]; eMap = 5'd1;
    end else begin
      eR = ~a[7]; eX = ~a[6]; eB = ~a[5]; eW = b[7];
      eSrc = {1'b0, ~b[6:3]}; eLen = {1'b0, b[2]}; pp = b[1:0];
      if (kind == 1) begin
        tag = "R5"; eMap = a[4:0]; bad = (a[4:0] == 5'd0);
      end else begin
        tag = "R6"; eRH = ~a[4]; eMap = {2'b00, a[2:0]};
        eSrc = {~c[3], ~b[6:3]}; eLen = c[6:5]; eEv = 1;
        eZ = c[7]; eBc = c[4]; eMask = c[2:0];
        bad = a[3] || !b[2] || (c[6:5] == 2'b11) || (a[2:0] == 3'd0);
      end
    end
    if (bad) begin
      chk("R9 invalid strobe", {62'd0, resultValid, invalidOut}, 64'd1);
    end else begin
      chk("R10 result strobe", {62'd0, resultValid, invalidOut}, 64'd2);
      chk(tag, {eR, extR, eX, extX, eB, extB, eRH, extRHi},
               {eR, eR, eX, eX, eB, eB, eRH, eRH});
      chk(tag, {wBit, srcReg, opMap, isEvex, zeroMask, bcastRc, maskReg},
               {eW, eSrc, eMap, eEv, eZ, eBc, eMask});
      chk("R7 mandPrefix", {56'd0, mandPrefix}, {56'd0, prefixOf(pp)});
      chk("R8 vecLen", {62'd0, vecLen}, {62'd0, eLen});
      chk("R12 opcode", {56'd0, opcode}, {56'd0, op});
    end
    chk("R3 not ready at strobe", {63'd0, byteReady}, 64'd0);
    @(negedge clk);
    chk("R10 strobe one cycle", {61'd0, resultValid, invalidOut, byteReady}, 64'd0);
  endtask

  initial begin
    repeat (CLK_PERIOD * 0 + 200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset", {61'd0, byteReady, resultValid, invalidOut}, 64'd0);

    // R2 non-lead start ignored
    startLead(8'h90);
    byteValid = 1'b1; byteData = 8'h11;
    @(negedge clk);
    chk("R2 bad lead ignored", {61'd0, byteReady, resultValid, invalidOut}, 64'd0);
    byteValid = 1'b0;

    // R2 start during a parse is ignored: short form still takes 2 bytes
    startLead(8'hC5);
    startLead(8'h62);
    sendByte(8'hF9);
    sendByte(8'h58);
    chk("R2 busy start ignored", {61'd0, resultValid, isEvex, byteReady}, 64'd4);
    chk("R12 opcode", {56'd0, opcode}, 64'h58);
    @(negedge clk);

    // R11 stalls: long form with idle gaps
    startLead(8'hC4);
    repeat (3) @(negedge clk);
    chk("R11 waiting ready", {61'd0, byteReady, resultValid, invalidOut}, 64'd4);
    sendByte(8'hE2);
    repeat (4) @(negedge clk);
    chk("R11 no strobe on stall", {61'd0, byteReady, resultValid, invalidOut}, 64'd4);
    sendByte(8'h7D);
    sendByte(8'h0B);
    chk("R11 strobe after stall", {61'd0, byteReady, resultValid, invalidOut}, 64'd2);
    chk("R5 map", {59'd0, opMap}, 64'd2);
    @(negedge clk);

    // sweeps
    for (int i = 0; i < 256; i++) runCase(0, 8'(i), 8'h00, 8'h00, 8'(i) ^ 8'hA5);
    for (int i = 0; i < 256; i++) runCase(1, 8'(i), {8'(i)}[3:0] == 4'd0 ? 8'hFF : {4'(i), 4'(i >> 4)}, 8'h00, 8'(i));
    for (int i = 0; i < 256; i++) runCase(2, 8'(i), 8'h7D, 8'h2A, 8'h3C);
    for (int i = 0; i < 256; i++) runCase(2, 8'h51, 8'(i), 8'h45, 8'(255 - i));
    for (int i = 0; i < 256; i++) runCase(2, 8'hA2, 8'h3E, 8'(i), 8'(i));

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule